// File: doc/BRIEF.md
# DMA Channel Interrupt Hub

This block gathers interrupt events from the channels of a DMA engine and turns them into software-visible status and interrupt lines. It has eight channels and five event kinds: transfer complete, block complete, source transaction complete, destination transaction complete and error. Each kind keeps one sticky raw bit per channel. A channel's raw bit is set by a single-cycle pulse on that channel's event input.

Every kind also has a mask register. The visible status of a kind is its raw bits ANDed with its mask and with a per-channel enable register. A write-one-to-clear port removes raw bits. For each kind, the status bits are ORed into one summary bit. A single interrupt output carries the OR of the whole summary, registered for one cycle.

Software uses a flat register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `dma_irq_hub`

## Requirements
- R1: After a synchronous active-low reset, all raw, mask and status bits, the summary and `irq_out` are 0, and the per-channel enable register reads 0x00FF.
- R2: A pulse on `evt_pulse[t*8+c]` sets raw bit c of kind t at the next clock edge. The bit then stays set until it is cleared or overwritten. The kinds are numbered 0 transfer complete, 1 block complete, 2 source transaction, 3 destination transaction and 4 error.
- R3: A mask write updates mask bit c from `reg_wdata[c]` only when `reg_wdata[8+c]` is 1. All other mask bits keep their value.
- R4: Status of kind t equals raw AND mask AND enable. Raw bits still set while the channel's enable bit is 0.
- R5: Writing 1 to bit c of a clear register clears raw bit c of that kind at the edge, and with it the status bit. Writing 0 leaves the bit unchanged. A clear register reads as 0.
- R6: When an event and a clear or raw write hit the same bit in the same cycle, the event wins and the bit is 1.
- R7: `irq_type[t]` is the OR of the status bits of kind t, so error is bit 4 and transfer complete is bit 0. The same value reads at the summary address.
- R8: `irq_out` equals the OR of `irq_type` as it was one cycle earlier.
- R9: A write to a raw register loads `reg_wdata[7:0]` into the raw bits, for test use.
- R10: Address map. `reg_addr[4:3]` selects the register class: 0 raw, 1 mask, 2 status, 3 clear. `reg_addr[2:0]` selects the kind 0..4. Address 0x0F is the enable register, written as plain bits 7:0. Address 0x17 is the summary. Writes to status, the summary or unused addresses are ignored. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address (class, kind) |
| reg_wdata | input | 16 | Write data; bits 15:8 are the write-select bits for mask writes |
| reg_rdata | output | 16 | Combinational read data |
| evt_pulse | input | 40 | Event pulses, kind t channel c at bit t*8+c |
| irq_type | output | 5 | Per-kind OR of masked status |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
A raw bit that is lost or sticks shows up on `irq_type` within the same cycle that the matching mask and enable are set. It shows up on `irq_out` one cycle later. A mask bit corrupted by a partial write only becomes visible once an event of that kind and channel arrives, so the bench reads the mask and status registers back after every write. Same-cycle collisions between events and clears or raw writes are exercised both directed and at random, because a wrong priority drops a pending interrupt without any other sign.

// File: rtl/dih_pkg.sv
// Shared constants and types for the DMA interrupt hub.
// Assumes a 5-bit register address split as {class[1:0], kind[2:0]}.
package dih_pkg;
    localparam int N_TYPE = 5;
    localparam logic [2:0] SEL_AUX = 3'd7;

    typedef enum logic [1:0] {
        K_RAW  = 2'd0,
        K_MASK = 2'd1,
        K_STAT = 2'd2,
        K_CLR  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/dih_type_slice.sv
// One event kind: sticky raw bits, selective-write mask and gated status.
// Assumes at most one of raw_wr, clr_wr and mask_wr is high per cycle.
// Events always win over a same-cycle clear or raw write.
module dih_type_slice #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] evt,
    input  logic            raw_wr,
    input  logic            clr_wr,
    input  logic            mask_wr,
    input  logic [N_CH-1:0] wr_val,
    input  logic [N_CH-1:0] wr_sel,
    input  logic [N_CH-1:0] ch_en,
    output logic [N_CH-1:0] raw_q,
    output logic [N_CH-1:0] mask_q,
    output logic [N_CH-1:0] stat
);
    logic [N_CH-1:0] raw_base;
    logic [N_CH-1:0] raw_nxt;

    // Next raw value: test load, or clear, then OR in the events.
    always_comb begin
        if (raw_wr)
            raw_base = wr_val;
        else if (clr_wr)
            raw_base = raw_q & ~wr_val;
        else
            raw_base = raw_q;
        raw_nxt = raw_base | evt;
    end

    // Raw status register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= '0;
        else
            raw_q <= raw_nxt;
    end

    // Mask register; only selected bits take the written value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_wr)
            mask_q <= (mask_q & ~wr_sel) | (wr_val & wr_sel);
    end

    // Status visible to software and the summary.
    assign stat = raw_q & mask_q & ch_en;

    p_evt_sets_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((raw_q & $past(evt)) == $past(evt)));

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> ((mask_q & ~$past(wr_sel)) == ($past(mask_q) & ~$past(wr_sel))));

    p_clr_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((raw_q & $past(wr_val) & ~$past(evt)) == '0));

    p_raw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_wr && !clr_wr && evt == '0) |=> $stable(raw_q));
endmodule

// File: rtl/dih_irq_merge.sv
// Reduces per-kind status to a summary vector and a registered interrupt.
// Assumes stat_flat packs kind t at bits [t*N_CH +: N_CH].
module dih_irq_merge #(
    parameter int N_TYPE = 5,
    parameter int N_CH   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_TYPE*N_CH-1:0] stat_flat,
    output logic [N_TYPE-1:0]      irq_type,
    output logic                   irq_out
);
    genvar t;
    generate
        for (t = 0; t < N_TYPE; t++) begin : g_or
            assign irq_type[t] = |stat_flat[t*N_CH +: N_CH];
        end
    endgenerate

    // One-cycle registered combined interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_out <= 1'b0;
        else
            irq_out <= |irq_type;
    end

    p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|stat_flat)));
endmodule

// File: rtl/dma_irq_hub.sv
// DMA interrupt hub top: decodes register writes, holds the channel
// enable register, instantiates one slice per kind and muxes reads.
// Assumes single-cycle writes and combinational reads.
module dma_irq_hub
    import dih_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [4:0]             reg_addr,
    input  logic [2*N_CH-1:0]      reg_wdata,
    output logic [2*N_CH-1:0]      reg_rdata,
    input  logic [N_TYPE*N_CH-1:0] evt_pulse,
    output logic [N_TYPE-1:0]      irq_type,
    output logic                   irq_out
);
    localparam int DW = 2 * N_CH;

    reg_kind_e              kind;
    logic [2:0]             sel;
    logic [N_CH-1:0]        en_q;
    logic [N_CH-1:0]        raw_all  [N_TYPE];
    logic [N_CH-1:0]        mask_all [N_TYPE];
    logic [N_TYPE*N_CH-1:0] stat_flat;

    assign kind = reg_kind_e'(reg_addr[4:3]);
    assign sel  = reg_addr[2:0];

    // Per-channel enable register, all enabled at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '1;
        else if (reg_wr && kind == K_MASK && sel == SEL_AUX)
            en_q <= reg_wdata[N_CH-1:0];
    end

    genvar t;
    generate
        for (t = 0; t < N_TYPE; t++) begin : g_slice
            dih_type_slice #(.N_CH(N_CH)) u_slice (
                .clk     (clk),
                .rst_n   (rst_n),
                .evt     (evt_pulse[t*N_CH +: N_CH]),
                .raw_wr  (reg_wr && kind == K_RAW  && sel == 3'(t)),
                .clr_wr  (reg_wr && kind == K_CLR  && sel == 3'(t)),
                .mask_wr (reg_wr && kind == K_MASK && sel == 3'(t)),
                .wr_val  (reg_wdata[N_CH-1:0]),
                .wr_sel  (reg_wdata[DW-1:N_CH]),
                .ch_en   (en_q),
                .raw_q   (raw_all[t]),
                .mask_q  (mask_all[t]),
                .stat    (stat_flat[t*N_CH +: N_CH])
            );
        end
    endgenerate

    dih_irq_merge #(.N_TYPE(N_TYPE), .N_CH(N_CH)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_flat (stat_flat),
        .irq_type  (irq_type),
        .irq_out   (irq_out)
    );

    // Read multiplexer; clear registers and unused addresses read zero.
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < N_TYPE; k++) begin
            if (sel == 3'(k)) begin
                case (kind)
                    K_RAW:   reg_rdata[N_CH-1:0] = raw_all[k];
                    K_MASK:  reg_rdata[N_CH-1:0] = mask_all[k];
                    K_STAT:  reg_rdata[N_CH-1:0] = stat_flat[k*N_CH +: N_CH];
                    default: reg_rdata = '0;
                endcase
            end
        end
        if (sel == SEL_AUX && kind == K_MASK)
            reg_rdata[N_CH-1:0] = en_q;
        if (sel == SEL_AUX && kind == K_STAT)
            reg_rdata[N_TYPE-1:0] = irq_type;
    end

    p_clr_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_CLR) |-> (reg_rdata == '0));

    p_reset_en_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (en_q == '1 && irq_out == 1'b0));
endmodule

// File: tb/dma_irq_hub_tb.sv
`timescale 1ns/1ps
module dma_irq_hub_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [39:0] evt_pulse = '0;
    logic [4:0]  irq_type;
    logic        irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] mraw  [5];
    logic [7:0] mmask [5];
    logic [7:0] men;

    always #2 clk = ~clk;

    dma_irq_hub u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .irq_type(irq_type), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic logic [4:0] model_sum();
        logic [4:0] s;
        for (int t = 0; t < 5; t++) s[t] = |(mraw[t] & mmask[t] & men);
        return s;
    endfunction

    function automatic logic [15:0] model_read(input logic [4:0] a);
        logic [15:0] r = '0;
        if (a[2:0] < 3'd5) begin
            case (a[4:3])
                2'd0: r[7:0] = mraw[a[2:0]];
                2'd1: r[7:0] = mmask[a[2:0]];
                2'd2: r[7:0] = mraw[a[2:0]] & mmask[a[2:0]] & men;
                default: r = '0;
            endcase
        end else if (a == 5'h0F) r[7:0] = men;
        else if (a == 5'h17) r[4:0] = model_sum();
        return r;
    endfunction

    task automatic model_step(input logic wr, input logic [4:0] a,
                              input logic [15:0] d, input logic [39:0] ev);
        for (int t = 0; t < 5; t++) begin
            if (wr && a[4:3] == 2'd0 && a[2:0] == 3'(t)) mraw[t] = d[7:0];
            else if (wr && a[4:3] == 2'd3 && a[2:0] == 3'(t)) mraw[t] = mraw[t] & ~d[7:0];
            mraw[t] = mraw[t] | ev[t*8 +: 8];
            if (wr && a[4:3] == 2'd1 && a[2:0] == 3'(t))
                mmask[t] = (mmask[t] & ~d[15:8]) | (d[7:0] & d[15:8]);
        end
        if (wr && a == 5'h0F) men = d[7:0];
    endtask

    // One clocked operation; checks the registered interrupt (R8).
    task automatic cyc(input logic wr, input logic [4:0] a,
                       input logic [15:0] d, input logic [39:0] ev);
        logic exp_irq;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_pulse = ev;
        @(posedge clk);
        exp_irq = |model_sum();
        model_step(wr, a, d, ev);
        #1;
        check("R8 irq_out", {15'd0, irq_out}, {15'd0, exp_irq});
    endtask

    // Idle read of one address plus the summary outputs (R7, R10).
    task automatic rd(input string tag, input logic [4:0] a);
        @(negedge clk);
        reg_wr = 1'b0; evt_pulse = '0; reg_addr = a;
        #1;
        check(tag, reg_rdata, model_read(a));
        check("R7 irq_type", {11'd0, irq_type}, {11'd0, model_sum()});
    endtask

    function automatic logic [39:0] ev1(input int t, input int c);
        return 40'd1 << (t*8 + c);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int t = 0; t < 5; t++) begin mraw[t] = '0; mmask[t] = '0; end
        men = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 irq_out reset", {15'd0, irq_out}, 16'd0);
        rd("R1 raw reset", 5'h00);
        rd("R1 mask reset", 5'h0C);
        rd("R1 status reset", 5'h14);
        rd("R1 enable reset", 5'h0F);
        rd("R1 summary reset", 5'h17);

        // R4: raw sets with channel disabled, status stays 0
        cyc(1, 5'h0F, 16'h0000, '0);
        cyc(1, 5'h0C, 16'hFFFF, '0);
        cyc(0, 5'h00, 16'h0000, ev1(4, 3));
        rd("R2 raw after error event", 5'h04);
        rd("R4 status gated by enable", 5'h14);
        cyc(1, 5'h0F, 16'h00FF, '0);
        rd("R4 status after enable", 5'h14);
        rd("R7 error summary bit4", 5'h17);
        cyc(0, 5'h00, 16'h0000, '0);

        // R3: selective mask writes
        cyc(1, 5'h0C, 16'h0100, '0);
        rd("R3 mask bit0 cleared only", 5'h0C);
        cyc(1, 5'h0C, 16'h00FF, '0);
        rd("R3 mask no select no change", 5'h0C);

        // R5: clear semantics
        cyc(1, 5'h1C, 16'h00F7, '0);
        rd("R5 clear zeros unrelated", 5'h04);
        rd("R5 clear reads zero", 5'h1C);
        cyc(1, 5'h1C, 16'h0008, '0);
        rd("R5 raw cleared", 5'h04);
        rd("R5 status cleared", 5'h14);

        // R6: event beats clear and raw write
        cyc(0, 5'h00, 16'h0000, ev1(0, 5));
        cyc(1, 5'h18, 16'h0020, ev1(0, 5));
        rd("R6 event beats clear", 5'h00);
        cyc(1, 5'h01, 16'h0000, ev1(1, 2));
        rd("R6 event beats raw write", 5'h01);

        // R9, R10
        cyc(1, 5'h02, 16'h00A5, '0);
        rd("R9 raw load", 5'h02);
        cyc(1, 5'h12, 16'h00FF, '0);
        rd("R10 status write ignored", 5'h12);
        cyc(1, 5'h05, 16'h00FF, '0);
        rd("R10 unused address", 5'h05);
        rd("R10 unused class read", 5'h1F);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [63:0] r;
            logic [4:0]  a;
            logic [15:0] d;
            int op;
            r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            op = int'($urandom % 6);
            a = {2'(op % 4), 3'($urandom % 8)};
            if (op == 3 && ($urandom % 3) == 0) a = 5'h0F;
            d = 16'($urandom);
            cyc(op < 4, a, d, r[39:0]);
            rd("R2 R3 R4 R5 R9 random read", 5'($urandom % 32));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule